// File: doc/BRIEF.md
# Shared-Bus Arbiter with DMA Block Engine and Debug Halt Gate

This block decides, cycle by cycle, who owns a single memory bus shared by one DMA channel and a CPU. The DMA channel is programmed through a one-cycle configuration write. The write carries an enable bit, a transfer count, a repeat selector and an interleave selector. Once enabled, a trigger pulse starts a block of transfers. Each transfer appears as a one-cycle strobe together with the DMA grant. A separate pulse marks the final transfer of a block. Addresses and data are handled elsewhere.

When interleaving is selected, the DMA takes at most eight cycles out of every ten-cycle window and leaves the other two to the CPU. Without interleaving, an active block takes every cycle. In repeat mode the count is reloaded as soon as a block ends, and the next block follows without a gap. This continues until software writes the enable bit low. A debug halt request is acknowledged only after the bus has been free of DMA requests for three cycles and only while the CPU is not asking for the bus. Because of this, a repeating interleaved channel keeps a debugger locked out for as long as it stays enabled.

All outputs are registered. Each decision taken at a clock edge from the inputs sampled at that edge shows up on the outputs during the following cycle. The reset is synchronous and active-high.

Top module: `dmaarb_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge and the channel enable (`ch_en`) is cleared.
- R2: A `trig` sampled while `ch_en` is 1, no block is in progress and the programmed count is nonzero starts a block. The first transfer (`dma_gnt` and `xfer_stb` both 1) appears in the cycle after the trigger's own cycle.
- R3: A block programmed with count N produces exactly N transfer strobes. `blk_done` is a one-cycle pulse that coincides with the N-th strobe.
- R4: When repeat is 0 (single-shot), `ch_en` reads 0 in the cycle of the final strobe. Later triggers are ignored until the channel is enabled again by a configuration write.
- R5: When repeat is 1, the count reloads at the end of each block and the next transfer occurs in the very next cycle. Blocks keep following each other while `ch_en` stays 1.
- R6: When interleave is 1, each block runs in ten-cycle windows that start when the block starts. The first eight cycles of a window carry DMA transfers and the last two carry none. The window position advances only while the DMA requests the bus.
- R7: When interleave is 0, an active block takes the bus in every cycle, and the DMA wins over a simultaneous CPU request.
- R8: `cpu_gnt` is 1 in a cycle exactly when `cpu_req` was high at the preceding edge and the DMA was not granted at that edge. `cpu_gnt` and `dma_gnt` are never both 1.
- R9: A configuration write with enable 0 aborts the block. A transfer already decided at that same edge still appears, but no strobe appears in any later cycle and no `blk_done` is produced.
- R10: `halt_ack` becomes 1 only when, at the edge, `dbg_halt_req` is high, `cpu_req` is low, the DMA is not requesting, and the DMA did not request at the three edges before it. It is therefore 1 in the fourth cycle after the last transfer cycle at the earliest.
- R11: `halt_ack` returns to 0 in the cycle after `dbg_halt_req` is sampled low, or `cpu_req` is sampled high.
- R12: A trigger sampled while `ch_en` is 0, or while the programmed count is 0, starts nothing and leaves `ch_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_en | input | 1 | Channel enable value written by `cfg_wr` |
| cfg_repeat | input | 1 | 1 = repeat blocks, 0 = single-shot |
| cfg_burst | input | 1 | 1 = 8-of-10 interleave, 0 = DMA takes every cycle |
| cfg_size | input | SIZE_W | Transfers per block |
| dma_trig | input | 1 | Block start trigger |
| cpu_req | input | 1 | CPU bus request |
| dbg_halt_req | input | 1 | Debug halt request |
| dma_gnt | output | 1 | DMA owns the bus this cycle |
| cpu_gnt | output | 1 | CPU owns the bus this cycle |
| xfer_stb | output | 1 | One DMA transfer occurs this cycle |
| blk_done | output | 1 | Final transfer of a block |
| halt_ack | output | 1 | Debug halt acknowledged |
| ch_en | output | 1 | Current channel enable |

## Verification
The checker assumes that every input is synchronous to `clk` and settles before the sampling edge. It also assumes that a configuration write aimed at a running block either aborts it or rewrites the settings it already has, never a different count or mode in the middle of a block. The stimulus respects both assumptions. Every input changes two nanoseconds after a rising edge. Each configuration write issued while a block is active either clears the enable or repeats the current settings. The halt checks take for granted that halt and CPU requests come from outside and may be held for any length of time, so the bench holds them for long stretches in both states.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  typedef enum logic {REP_ONCE = 1'b0, REP_LOOP = 1'b1} rep_e;
  typedef enum logic {ARB_SOLID = 1'b0, ARB_SHARED = 1'b1} arb_e;
endpackage

// File: rtl/dmaarb_chan.sv
module dmaarb_chan
  import dmaarb_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  rep_e              cfg_rep,
  input  arb_e              cfg_arb,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              trig,
  input  logic              xfer_now,
  output logic              chan_req,
  output logic              blk_start,
  output logic              blk_last,
  output logic              en_o,
  output rep_e              rep_o,
  output arb_e              arb_o
);
  logic              en_q;
  logic              act_q;
  logic [SIZE_W-1:0] cnt_q;
  logic [SIZE_W-1:0] size_q;
  rep_e              rep_q;
  arb_e              arb_q;
  logic              size_nz;
  logic              fire;

  assign size_nz   = (size_q != '0);
  assign chan_req  = en_q && act_q && (cnt_q != '0);
  assign blk_last  = xfer_now && (cnt_q == SIZE_W'(1));
  assign fire      = en_q && !act_q && trig && size_nz;
  assign blk_start = fire || (blk_last && (rep_q == REP_LOOP) && size_nz);
  assign en_o      = en_q;
  assign rep_o     = rep_q;
  assign arb_o     = arb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      size_q <= '0;
      rep_q  <= REP_ONCE;
      arb_q  <= ARB_SOLID;
    end else begin
      if (xfer_now) cnt_q <= cnt_q - SIZE_W'(1);
      if (blk_last) begin
        if (rep_q == REP_LOOP && size_nz) begin
          cnt_q <= size_q;
        end else begin
          act_q <= 1'b0;
          if (rep_q == REP_ONCE) en_q <= 1'b0;
        end
      end
      if (fire) begin
        act_q <= 1'b1;
        cnt_q <= size_q;
      end
      if (cfg_wr) begin
        en_q   <= cfg_en;
        size_q <= cfg_size;
        rep_q  <= cfg_rep;
        arb_q  <= cfg_arb;
        if (!cfg_en) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmaarb_ilv.sv
module dmaarb_ilv #(
  parameter int WIN_LEN   = 10,
  parameter int DMA_SLOTS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic restart,
  output logic slot_dma
);
  localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [PW-1:0] pos_q;

  assign slot_dma = (pos_q < PW'(DMA_SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (restart) begin
      pos_q <= '0;
    end else if (req) begin
      pos_q <= (pos_q == PW'(WIN_LEN - 1)) ? '0 : pos_q + PW'(1);
    end
  end
endmodule

// File: rtl/dmaarb_halt.sv
module dmaarb_halt #(
  parameter int QUIET_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic dma_busy,
  input  logic cpu_req,
  input  logic halt_req,
  output logic halt_ack
);
  localparam int QW = $clog2(QUIET_CYC + 1);

  logic [QW-1:0] quiet_q;
  logic          settled;

  assign settled = (quiet_q >= QW'(QUIET_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q  <= '0;
      halt_ack <= 1'b0;
    end else begin
      if (dma_busy)     quiet_q <= '0;
      else if (!settled) quiet_q <= quiet_q + QW'(1);
      halt_ack <= halt_req && !cpu_req && settled && !dma_busy;
    end
  end
endmodule

// File: rtl/dmaarb_top.sv
module dmaarb_top
  import dmaarb_pkg::*;
#(
  parameter int SIZE_W    = 8,
  parameter int WIN_LEN   = 10,
  parameter int DMA_SLOTS = 8,
  parameter int QUIET_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_repeat,
  input  logic              cfg_burst,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              dma_trig,
  input  logic              cpu_req,
  input  logic              dbg_halt_req,
  output logic              dma_gnt,
  output logic              cpu_gnt,
  output logic              xfer_stb,
  output logic              blk_done,
  output logic              halt_ack,
  output logic              ch_en
);
  logic chan_req;
  logic blk_start;
  logic blk_last;
  logic slot_dma;
  logic slot_ok;
  logic xfer_now;
  rep_e mode_rep;
  arb_e mode_arb;

  assign slot_ok  = (mode_arb == ARB_SOLID) || slot_dma;
  assign xfer_now = chan_req && slot_ok;

  dmaarb_chan #(.SIZE_W(SIZE_W)) u_chan (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_en   (cfg_en),
    .cfg_rep  (rep_e'(cfg_repeat)),
    .cfg_arb  (arb_e'(cfg_burst)),
    .cfg_size (cfg_size),
    .trig     (dma_trig),
    .xfer_now (xfer_now),
    .chan_req (chan_req),
    .blk_start(blk_start),
    .blk_last (blk_last),
    .en_o     (ch_en),
    .rep_o    (mode_rep),
    .arb_o    (mode_arb)
  );

  dmaarb_ilv #(.WIN_LEN(WIN_LEN), .DMA_SLOTS(DMA_SLOTS)) u_ilv (
    .clk     (clk),
    .rst     (rst),
    .req     (chan_req),
    .restart (blk_start),
    .slot_dma(slot_dma)
  );

  dmaarb_halt #(.QUIET_CYC(QUIET_CYC)) u_halt (
    .clk     (clk),
    .rst     (rst),
    .dma_busy(chan_req),
    .cpu_req (cpu_req),
    .halt_req(dbg_halt_req),
    .halt_ack(halt_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_gnt  <= 1'b0;
      xfer_stb <= 1'b0;
      cpu_gnt  <= 1'b0;
      blk_done <= 1'b0;
    end else begin
      dma_gnt  <= xfer_now;
      xfer_stb <= xfer_now;
      cpu_gnt  <= cpu_req && !xfer_now;
      blk_done <= blk_last;
    end
  end
endmodule

// File: rtl/dmaarb_chk.sv
module dmaarb_chk
  import dmaarb_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic cfg_en,
  input logic cpu_req,
  input logic dbg_halt_req,
  input logic dma_gnt,
  input logic cpu_gnt,
  input logic xfer_stb,
  input logic blk_done,
  input logic halt_ack,
  input logic ch_en,
  input rep_e mode_rep
);
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(dma_gnt && cpu_gnt));

  p_cpu_src_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_gnt |-> $past(cpu_req));

  p_done_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> xfer_stb);

  p_once_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (blk_done && mode_rep == REP_ONCE) |-> !ch_en);

  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_en) |-> ##2 (!xfer_stb && !blk_done));

  p_halt_cpu_r10: assert property (@(posedge clk) disable iff (rst)
    halt_ack |-> ($past(dbg_halt_req) && !$past(cpu_req)));

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    halt_ack |-> (!xfer_stb && !$past(xfer_stb) && !$past(xfer_stb, 2)));

  p_release_r11: assert property (@(posedge clk) disable iff (rst)
    (!dbg_halt_req || cpu_req) |=> !halt_ack);
endmodule

bind dmaarb_top dmaarb_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr      (cfg_wr),
  .cfg_en      (cfg_en),
  .cpu_req     (cpu_req),
  .dbg_halt_req(dbg_halt_req),
  .dma_gnt     (dma_gnt),
  .cpu_gnt     (cpu_gnt),
  .xfer_stb    (xfer_stb),
  .blk_done    (blk_done),
  .halt_ack    (halt_ack),
  .ch_en       (ch_en),
  .mode_rep    (mode_rep)
);

// File: tb/dmaarb_top_tb.sv
module dmaarb_top_tb;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst, cfg_wr, cfg_en, cfg_repeat, cfg_burst, dma_trig, cpu_req, dbg_halt_req;
  logic [SW-1:0] cfg_size;
  logic dma_gnt, cpu_gnt, xfer_stb, blk_done, halt_ack, ch_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dmaarb_top #(.SIZE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_repeat(cfg_repeat), .cfg_burst(cfg_burst), .cfg_size(cfg_size),
    .dma_trig(dma_trig), .cpu_req(cpu_req), .dbg_halt_req(dbg_halt_req),
    .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt), .xfer_stb(xfer_stb),
    .blk_done(blk_done), .halt_ack(halt_ack), .ch_en(ch_en)
  );

  // vector: {wr,en,rep,burst,size[3:0],trig,cpu,halt} {dma,cpu,stb,done,ack,en}
  localparam logic [16:0] VEC [8] = '{
    17'b1_1_0_0_0011_0_1_0_0_1_0_0_0_1,
    17'b0_0_0_0_0000_1_1_0_0_1_0_0_0_1,
    17'b0_0_0_0_0000_0_1_0_1_0_1_0_0_1,
    17'b0_0_0_0_0000_0_1_0_1_0_1_0_0_1,
    17'b0_0_0_0_0000_0_1_0_1_0_1_1_0_0,
    17'b0_0_0_0_0000_0_1_0_0_1_0_0_0_0,
    17'b0_0_0_0_0000_1_1_0_0_1_0_0_0_0,
    17'b0_0_0_0_0000_0_0_0_0_0_0_0_0_0
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in();
    cfg_wr = 0; cfg_en = 0; cfg_repeat = 0; cfg_burst = 0; cfg_size = '0;
    dma_trig = 0; cpu_req = 0; dbg_halt_req = 0;
  endtask

  task automatic cfg(input logic en, input logic rep, input logic bst, input int sz);
    cfg_wr = 1; cfg_en = en; cfg_repeat = rep; cfg_burst = bst; cfg_size = SW'(sz);
    tick();
    cfg_wr = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int stb_n, done_n;
    idle_in();
    rst = 1;
    tick(); tick();
    // R1 reset state
    chk("R1 dma_gnt", dma_gnt, 0); chk("R1 cpu_gnt", cpu_gnt, 0);
    chk("R1 stb", xfer_stb, 0); chk("R1 done", blk_done, 0);
    chk("R1 ack", halt_ack, 0); chk("R1 en", ch_en, 0);
    rst = 0;
    tick();

    // table: single-shot plain block of 3 with CPU contending (R2 R3 R4 R7 R8)
    for (int i = 0; i < 8; i++) begin
      logic [16:0] v;
      v = VEC[i];
      cfg_wr = v[16]; cfg_en = v[15]; cfg_repeat = v[14]; cfg_burst = v[13];
      cfg_size = SW'(v[12:9]); dma_trig = v[8]; cpu_req = v[7]; dbg_halt_req = v[6];
      tick();
      chk($sformatf("R2 R7 row%0d dma_gnt", i), dma_gnt, int'(v[5]));
      chk($sformatf("R8 row%0d cpu_gnt", i), cpu_gnt, int'(v[4]));
      chk($sformatf("R3 row%0d stb", i), xfer_stb, int'(v[3]));
      chk($sformatf("R3 row%0d done", i), blk_done, int'(v[2]));
      chk($sformatf("R10 row%0d ack", i), halt_ack, int'(v[1]));
      chk($sformatf("R4 row%0d en", i), ch_en, int'(v[0]));
    end
    idle_in();

    // R6 interleaved single-shot block of 12, CPU always asking
    cfg(1, 0, 1, 12);
    cpu_req = 1; dma_trig = 1; tick(); dma_trig = 0;
    stb_n = 0;
    for (int i = 0; i < 20; i++) begin
      int e;
      tick();
      e = (i < 8 || (i >= 10 && i < 14)) ? 1 : 0;
      chk($sformatf("R6 slot%0d dma", i), dma_gnt, e);
      chk($sformatf("R8 slot%0d cpu", i), cpu_gnt, 1 - e);
      chk($sformatf("R3 slot%0d done", i), blk_done, (i == 13) ? 1 : 0);
      stb_n += xfer_stb;
    end
    chk("R3 burst strobe count", stb_n, 12);
    idle_in();

    // R5 repeating interleaved blocks of 4 lock out halt (R10)
    cfg(1, 1, 1, 4);
    dma_trig = 1; tick(); dma_trig = 0;
    stb_n = 0; done_n = 0;
    tick(); stb_n += xfer_stb; done_n += blk_done;
    dbg_halt_req = 1;
    for (int i = 1; i < 40; i++) begin
      tick();
      stb_n += xfer_stb; done_n += blk_done;
      if (halt_ack) chk("R10 ack during repeat", 1, 0);
    end
    chk("R5 continuous strobes", stb_n, 40);
    chk("R5 block count", done_n, 10);
    cfg_wr = 1; cfg_en = 0; cfg_repeat = 1; cfg_burst = 1; cfg_size = SW'(4);
    tick(); cfg_wr = 0;
    chk("R9 decided strobe at abort", xfer_stb, 1);
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk($sformatf("R9 post-abort stb%0d", i), xfer_stb, 0);
      chk($sformatf("R10 ack after %0d quiet", i), halt_ack, (i == 4) ? 1 : 0);
    end
    chk("R9 en cleared", ch_en, 0);

    // R10 CPU request blocks ack, R11 withdrawal
    cpu_req = 1; tick();
    chk("R10 ack with cpu_req", halt_ack, 0);
    chk("R8 idle cpu_gnt", cpu_gnt, 1);
    cpu_req = 0; tick();
    chk("R10 ack when cpu quiet", halt_ack, 1);
    dbg_halt_req = 0; tick();
    chk("R11 ack drops", halt_ack, 0);

    // R9 abort plain block mid-way
    cfg(1, 0, 0, 8);
    dma_trig = 1; tick(); dma_trig = 0;
    tick(); tick(); tick();
    chk("R2 strobe before abort", xfer_stb, 1);
    cfg_wr = 1; cfg_en = 0; cfg_size = SW'(8); tick(); cfg_wr = 0;
    stb_n = 0; done_n = 0;
    for (int i = 0; i < 5; i++) begin
      tick(); stb_n += xfer_stb; done_n += blk_done;
    end
    chk("R9 no strobe after abort", stb_n, 0);
    chk("R9 no done after abort", done_n, 0);

    // R12 trigger with zero count / while disabled
    cfg(1, 0, 0, 0);
    dma_trig = 1; tick(); dma_trig = 0;
    stb_n = 0;
    for (int i = 0; i < 4; i++) begin tick(); stb_n += xfer_stb; end
    chk("R12 zero count ignored", stb_n, 0);
    chk("R12 en kept", ch_en, 1);
    cfg(0, 0, 0, 5);
    dma_trig = 1; tick(); dma_trig = 0;
    stb_n = 0;
    for (int i = 0; i < 4; i++) begin tick(); stb_n += xfer_stb; end
    chk("R12 disabled ignored", stb_n, 0);
    chk("R12 en stays low", ch_en, 0);

    // R1 reset during a repeating block
    cfg(1, 1, 0, 3);
    dma_trig = 1; tick(); dma_trig = 0;
    tick(); tick();
    rst = 1; tick(); rst = 0;
    chk("R1 mid-run stb", xfer_stb, 0);
    chk("R1 mid-run en", ch_en, 0);
    stb_n = 0;
    for (int i = 0; i < 4; i++) begin tick(); stb_n += xfer_stb; end
    chk("R1 quiet after reset", stb_n, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule